// File: doc/BRIEF.md
# Arithmetic Unit with Condition Flags Register

This block performs two-operand integer operations on W-bit words (64 by default). It covers signed and unsigned add, subtract, multiply and divide, bitwise AND, OR, XOR and NOT, logical shifts, and signed and unsigned compare. Every operation except divide finishes in one clock. Divide runs as a bit-serial restoring loop that needs W iterations. While it runs the unit reports itself busy and ignores new requests.

Each finished operation loads four flag bits into a W-bit condition register. These flags are less/negative, greater/positive, equal/zero and overflow, and they sit in the top four bit positions. All lower bits are reserved and always read zero. The register can also be loaded directly and read back.

A branch-test output is computed from a mask operand. It reports taken when every bit set in the mask is also set in the condition register.

Top module: `alu_cr_unit`

## Requirements
- R1: After a synchronous reset the outputs are zero: `result`, `remainder`, `res_valid`, `busy` and `cr_q`.
- R2: Opcodes 0 to 3 select signed add, unsigned add, signed subtract and unsigned subtract of `opa` and `opb`. The result wraps to W bits. Overflow is set on a two's complement range error for the signed forms, on a carry out for unsigned add, and on a borrow (`opa` < `opb`) for unsigned subtract.
- R3: Opcodes 4 (signed) and 5 (unsigned) multiply and return the low W bits of the product. Overflow is set when the full product is outside the W-bit range of the selected signedness.
- R4: Opcodes 6 to 11 are AND, OR, XOR, NOT of `opa`, shift-left and logical shift-right. The shifts move `opa` by `opb` places, and any count of W or more gives zero.
- R5: Flags live at bit W-1 (less/negative), W-2 (greater/positive), W-3 (equal/zero) and W-4 (overflow). Signed, bitwise and shift operations set the first three from the signed value of the result. Unsigned operations (1, 3, 5, 15) never set the less flag, set greater for a nonzero result and set equal for zero. Bitwise and shift operations clear overflow.
- R6: Opcodes 12 (signed) and 13 (unsigned) compare `opa` with `opb`. Exactly one of less, greater or equal is set, overflow is cleared, and `result` is zero.
- R7: Opcodes 14 (signed) and 15 (unsigned) divide `opa` by `opb`. The quotient goes to `result` and the remainder to `remainder`. Signed division truncates toward zero, and the remainder takes the sign of the dividend. The most negative value divided by -1 gives itself with remainder 0 and sets overflow. The flags follow the quotient.
- R8: Dividing by zero returns an all-ones quotient, returns the dividend as the remainder, and sets overflow.
- R9: For opcodes 0 to 13, `res_valid` pulses in the cycle after the accepting edge, and `remainder` is zero. A divide raises `busy` after its accepting edge and presents its result and `res_valid` W+1 edges after the accepting edge.
- R10: A request made while `busy` is high is ignored. It produces no `res_valid` and does not alter the divide outcome or the flags.
- R11: Asserting `cr_wr` loads the top four bits of `cr_wdata` into the condition register and clears the reserved bits. The direct load takes priority over a flag update in the same cycle.
- R12: `br_taken` is high exactly when every set bit of `br_mask` is also set in `cr_q`. An all-zero mask is always taken, and a mask touching a reserved bit is never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request an operation this cycle |
| op_code | input | 4 | Operation select (see requirements) |
| opa | input | W | First operand / dividend |
| opb | input | W | Second operand / divisor / shift count |
| cr_wr | input | 1 | Direct load of the condition register |
| cr_wdata | input | W | Value for the direct load |
| br_mask | input | W | Branch test mask |
| result | output | W | Result or quotient |
| remainder | output | W | Divide remainder, zero otherwise |
| res_valid | output | 1 | One-cycle pulse when `result` is new |
| busy | output | 1 | Divide in progress; requests ignored |
| cr_q | output | W | Condition register contents |
| br_taken | output | 1 | Branch condition satisfied |

## Verification
A corrupted divide iteration register shows up as a wrong quotient or remainder on the single `res_valid` pulse, W+1 edges after the start. A miscounted iteration counter moves that pulse off its cycle, so it is caught as a latency error. Wrong flag logic is visible in `cr_q` one cycle after the operation, and it then propagates into `br_taken` for every mask that follows. The bench therefore compares `result`, `remainder` and `cr_q` after every operation of a dense operand sweep, and it counts edges to the divide result.

// File: rtl/alucr_pkg.sv
package alucr_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDU = 4'd1,  OP_SUB  = 4'd2,  OP_SUBU = 4'd3,
    OP_MUL  = 4'd4,  OP_MULU = 4'd5,  OP_AND  = 4'd6,  OP_OR   = 4'd7,
    OP_XOR  = 4'd8,  OP_NOT  = 4'd9,  OP_SHL  = 4'd10, OP_SHR  = 4'd11,
    OP_CMP  = 4'd12, OP_CMPU = 4'd13, OP_DIV  = 4'd14, OP_DIVU = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic ov;
  } flags_t;
endpackage

// File: rtl/alu_comb.sv
module alu_comb
  import alucr_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output flags_t       flg
);
  localparam int SHW = $clog2(W);

  logic [W:0]     sum, dif;
  logic [2*W-1:0] ps, pu;
  logic [W-1:0]   shl, shr;
  logic           big_shift;
  logic           sgn_flags, is_cmp, ov;
  flags_t         cmp_f;

  always_comb begin
    sum = {1'b0, a} + {1'b0, b};
    dif = {1'b0, a} - {1'b0, b};
    ps  = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
    pu  = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    big_shift = |b[W-1:SHW];
    shl = big_shift ? '0 : (a << b[SHW-1:0]);
    shr = big_shift ? '0 : (a >> b[SHW-1:0]);
    res       = '0;
    ov        = 1'b0;
    sgn_flags = 1'b1;
    is_cmp    = 1'b0;
    cmp_f     = '0;
    case (alu_op_e'(op))
      OP_ADD:  begin res = sum[W-1:0]; ov = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]); end
      OP_ADDU: begin res = sum[W-1:0]; ov = sum[W]; sgn_flags = 1'b0; end
      OP_SUB:  begin res = dif[W-1:0]; ov = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]); end
      OP_SUBU: begin res = dif[W-1:0]; ov = dif[W]; sgn_flags = 1'b0; end
      OP_MUL:  begin res = ps[W-1:0]; ov = !((&ps[2*W-1:W-1]) || (~|ps[2*W-1:W-1])); end
      OP_MULU: begin res = pu[W-1:0]; ov = |pu[2*W-1:W]; sgn_flags = 1'b0; end
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      OP_SHL:  res = shl;
      OP_SHR:  res = shr;
      OP_CMP: begin
        is_cmp   = 1'b1;
        cmp_f.lt = $signed(a) < $signed(b);
        cmp_f.gt = $signed(a) > $signed(b);
        cmp_f.eq = (a == b);
      end
      OP_CMPU: begin
        is_cmp   = 1'b1;
        cmp_f.lt = a < b;
        cmp_f.gt = a > b;
        cmp_f.eq = (a == b);
      end
      default: res = '0;
    endcase
    if (is_cmp) begin
      flg = cmp_f;
    end else begin
      flg.lt = sgn_flags & res[W-1];
      flg.gt = sgn_flags ? (!res[W-1] && (|res)) : (|res);
      flg.eq = ~|res;
      flg.ov = ov;
    end
  end
endmodule

// File: rtl/alu_divider.sv
module alu_divider
  import alucr_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] q,
  output logic [W-1:0] r,
  output flags_t       flg
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  rem, quo, dvs, dvd;
  logic [CW-1:0] cnt;
  logic          sgn, neg_q, neg_r, dz, mo;
  logic [W:0]    shf, sub;
  logic          fits;
  logic [W-1:0]  ma, mb;

  always_comb begin
    shf  = {rem, quo[W-1]};
    sub  = shf - {1'b0, dvs};
    fits = shf >= {1'b0, dvs};
    ma   = (is_signed && a[W-1]) ? -a : a;
    mb   = (is_signed && b[W-1]) ? -b : b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; cnt <= '0;
      rem <= '0; quo <= '0; dvs <= '0; dvd <= '0;
      sgn <= 1'b0; neg_q <= 1'b0; neg_r <= 1'b0; dz <= 1'b0; mo <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        cnt   <= '0;
        rem   <= '0;
        quo   <= ma;
        dvs   <= mb;
        dvd   <= a;
        sgn   <= is_signed;
        neg_q <= is_signed && (a[W-1] ^ b[W-1]);
        neg_r <= is_signed && a[W-1];
        dz    <= ~|b;
        mo    <= is_signed && (a == {1'b1, {(W-1){1'b0}}}) && (&b);
      end else if (busy) begin
        rem <= fits ? sub[W-1:0] : shf[W-1:0];
        quo <= {quo[W-2:0], fits};
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    q = dz ? '1  : (neg_q ? -quo : quo);
    r = dz ? dvd : (neg_r ? -rem : rem);
    flg.lt = sgn & q[W-1];
    flg.gt = sgn ? (!q[W-1] && (|q)) : (|q);
    flg.eq = ~|q;
    flg.ov = dz | mo;
  end

  // R7: a finished nonzero-divisor division leaves a magnitude remainder below the divisor
  a_r7_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
    (done && !dz) |-> (rem < dvs));
  // R9: completion is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: busy ends exactly when done rises
  a_r9_busy_to_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

// File: rtl/alu_condreg.sv
module alu_condreg
  import alucr_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd_en,
  input  flags_t       upd_flags,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] mask,
  output logic [W-1:0] cr_q,
  output logic         taken
);
  localparam int RSV = W - 4;

  always_ff @(posedge clk) begin
    if (rst)
      cr_q <= '0;
    else if (wr_en)
      cr_q <= {wr_data[W-1:RSV], {RSV{1'b0}}};
    else if (upd_en)
      cr_q <= {upd_flags, {RSV{1'b0}}};
  end

  assign taken = ((mask & ~cr_q) == '0);

  // R11: reserved bits always read zero
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    cr_q[RSV-1:0] == '0);
  // R11: a direct load wins over a flag update
  a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cr_q[W-1:RSV] == $past(wr_data[W-1:RSV])));
  // R12: a mask touching reserved bits is never satisfied
  a_r12_reserved_mask: assert property (@(posedge clk) disable iff (rst)
    (|mask[RSV-1:0]) |-> !taken);
endmodule

// File: rtl/alu_cr_unit.sv
module alu_cr_unit
  import alucr_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cr_wr,
  input  logic [W-1:0] cr_wdata,
  input  logic [W-1:0] br_mask,
  output logic [W-1:0] result,
  output logic [W-1:0] remainder,
  output logic         res_valid,
  output logic         busy,
  output logic [W-1:0] cr_q,
  output logic         br_taken
);
  logic [W-1:0] c_res, d_q, d_r;
  flags_t       c_flg, d_flg, upd_flags;
  logic         d_busy, d_done, accept, is_div, upd_en;

  assign busy   = d_busy | d_done;
  assign is_div = (op_code[3:1] == 3'b111);
  assign accept = op_valid && !busy;

  alu_comb #(.W(W)) i_comb (
    .op(op_code), .a(opa), .b(opb), .res(c_res), .flg(c_flg)
  );

  alu_divider #(.W(W)) i_div (
    .clk(clk), .rst(rst), .start(accept && is_div), .is_signed(!op_code[0]),
    .a(opa), .b(opb), .busy(d_busy), .done(d_done), .q(d_q), .r(d_r), .flg(d_flg)
  );

  assign upd_en    = (accept && !is_div) || d_done;
  assign upd_flags = d_done ? d_flg : c_flg;

  alu_condreg #(.W(W)) i_cr (
    .clk(clk), .rst(rst), .upd_en(upd_en), .upd_flags(upd_flags),
    .wr_en(cr_wr), .wr_data(cr_wdata), .mask(br_mask), .cr_q(cr_q), .taken(br_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      remainder <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (accept && !is_div) begin
        result    <= c_res;
        remainder <= '0;
        res_valid <= 1'b1;
      end else if (d_done) begin
        result    <= d_q;
        remainder <= d_r;
        res_valid <= 1'b1;
      end
    end
  end

  // R9: a single-cycle operation produces its pulse on the next cycle
  a_r9_single_valid: assert property (@(posedge clk) disable iff (rst)
    (accept && !is_div) |=> res_valid);
  // R10: nothing completes while the divider iterates
  a_r10_quiet_while_busy: assert property (@(posedge clk) disable iff (rst)
    d_busy |=> !res_valid);
  // R6: a compare raises exactly one relation flag
  a_r6_cmp_one_flag: assert property (@(posedge clk) disable iff (rst)
    (accept && op_code[3:1] == 3'b110) |-> ($countones({c_flg.lt, c_flg.gt, c_flg.eq}) == 1));
  // R5: unsigned arithmetic never reports less-than
  a_r5_unsigned_no_lt: assert property (@(posedge clk) disable iff (rst)
    (accept && op_code[3:2] == 2'b00 && op_code[0]) |-> !c_flg.lt);
endmodule

// File: tb/test_alu_cr_unit.sv
`timescale 1ns/1ps
module test_alu_cr_unit;
  localparam int W = 8;
  localparam longint M = longint'(1) << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [W-1:0] opa = '0, opb = '0, cr_wdata = '0, br_mask = '0;
  logic cr_wr = 1'b0;
  logic [W-1:0] result, remainder, cr_q;
  logic res_valid, busy, br_taken;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  alu_cr_unit #(.W(W)) i_alu_cr_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .opa(opa), .opb(opb),
    .cr_wr(cr_wr), .cr_wdata(cr_wdata), .br_mask(br_mask), .result(result),
    .remainder(remainder), .res_valid(res_valid), .busy(busy), .cr_q(cr_q), .br_taken(br_taken)
  );

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint sx(longint v);
    return v[W-1] ? v - M : v;
  endfunction

  function automatic longint wrap(longint v);
    return v & (M - 1);
  endfunction

  function automatic logic [3:0] sfl(longint r, logic ov);
    return {sx(r) < 0, sx(r) > 0, r == 0, ov};
  endfunction

  function automatic logic [3:0] ufl(longint r, logic ov);
    return {1'b0, r != 0, r == 0, ov};
  endfunction

  function automatic string tag_of(int op);
    if (op < 4) return "R2";
    if (op < 6) return "R3";
    if (op < 12) return "R4";
    if (op < 14) return "R6";
    return "R7";
  endfunction

  task automatic model(input int op, input longint a, input longint b,
                       output longint r, output longint rm, output logic [3:0] f);
    longint sa, sb, t;
    sa = sx(a); sb = sx(b); rm = 0; r = 0; f = '0;
    case (op)
      0: begin t = sa + sb; r = wrap(t); f = sfl(r, t > M/2-1 || t < -M/2); end
      1: begin t = a + b;   r = wrap(t); f = ufl(r, t >= M); end
      2: begin t = sa - sb; r = wrap(t); f = sfl(r, t > M/2-1 || t < -M/2); end
      3: begin r = wrap(a - b); f = ufl(r, a < b); end
      4: begin t = sa * sb; r = wrap(t); f = sfl(r, t > M/2-1 || t < -M/2); end
      5: begin t = a * b;   r = wrap(t); f = ufl(r, t >= M); end
      6: begin r = a & b; f = sfl(r, 1'b0); end
      7: begin r = a | b; f = sfl(r, 1'b0); end
      8: begin r = a ^ b; f = sfl(r, 1'b0); end
      9: begin r = wrap(~a); f = sfl(r, 1'b0); end
      10: begin r = (b >= W) ? 0 : wrap(a << b); f = sfl(r, 1'b0); end
      11: begin r = (b >= W) ? 0 : (a >> b); f = sfl(r, 1'b0); end
      12: f = {sa < sb, sa > sb, sa == sb, 1'b0};
      13: f = {a < b, a > b, a == b, 1'b0};
      14: begin
        if (b == 0) begin r = M - 1; rm = a; f = sfl(r, 1'b1); end
        else begin
          r = wrap(sa / sb); rm = wrap(sa % sb);
          f = sfl(r, sa == -M/2 && sb == -1);
        end
      end
      default: begin
        if (b == 0) begin r = M - 1; rm = a; f = ufl(r, 1'b1); end
        else begin r = a / b; rm = a % b; f = ufl(r, 1'b0); end
      end
    endcase
  endtask

  task automatic run_op(int op, longint a, longint b);
    longint er, erm;
    logic [3:0] ef;
    int n;
    string tg;
    model(op, a, b, er, erm, ef);
    tg = (op >= 14 && b == 0) ? "R8" : tag_of(op);
    @(negedge clk);
    op_valid = 1'b1; op_code = op[3:0]; opa = a[W-1:0]; opb = b[W-1:0];
    @(negedge clk);
    op_valid = 1'b0;
    if (op >= 14) begin
      chk(busy == 1'b1, "R9 busy", busy, 1);
      n = 1;
      while (!res_valid && n < W + 8) begin
        @(negedge clk);
        n++;
      end
      chk(n == W + 2, "R9 latency", n, W + 2);
    end else begin
      chk(res_valid == 1'b1, "R9 valid", res_valid, 1);
    end
    chk(result == er[W-1:0], tg, result, er);
    chk(remainder == erm[W-1:0], tg, remainder, erm);
    chk(cr_q == {ef, {(W-4){1'b0}}}, "R5 flags", cr_q, {ef, {(W-4){1'b0}}});
  endtask

  function automatic longint pick(int i);
    longint c[9] = '{0, 1, 2, 7, 127, 128, 129, 254, 255};
    return (i < 9) ? c[i] : longint'((i - 9) * 17);
  endfunction

  task automatic check_branch(logic [W-1:0] m, bit exp);
    @(negedge clk);
    br_mask = m;
    #1;
    chk(br_taken == exp, "R12", br_taken, exp);
  endtask

  initial begin
    #1_000_000;
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(result == 0 && remainder == 0, "R1 result", result, 0);
    chk(res_valid == 0 && busy == 0, "R1 status", {res_valid, busy}, 0);
    chk(cr_q == 0, "R1 cr", cr_q, 0);

    // R2 R3 R4 R6: single-cycle sweep
    for (int op = 0; op < 14; op++)
      for (int i = 0; i < 25; i++)
        for (int j = 0; j < 25; j++)
          run_op(op, pick(i), pick(j));
    for (int s = 0; s < 12; s++) begin
      run_op(10, 8'hB5, s);
      run_op(11, 8'hB5, s);
    end

    // R7 R8: divide sweep
    for (int op = 14; op < 16; op++)
      for (int i = 0; i < 25; i++)
        for (int j = 0; j < 25; j++)
          run_op(op, pick(i), pick(j));

    // R10: request during divide is ignored
    @(negedge clk);
    op_valid = 1'b1; op_code = 4'd15; opa = 8'd100; opb = 8'd7;
    @(negedge clk);
    op_code = 4'd0; opa = 8'd200; opb = 8'd100;
    begin
      int pulses;
      pulses = 0;
      for (int k = 0; k < W + 4; k++) begin
        @(negedge clk);
        op_valid = (k < W - 1);
        if (res_valid) begin
          pulses++;
          chk(result == 8'd14 && remainder == 8'd2, "R10 outcome", {result, remainder}, {8'd14, 8'd2});
          chk(cr_q == 8'h40, "R10 flags", cr_q, 8'h40);
        end
      end
      chk(pulses == 1, "R10 pulses", pulses, 1);
      op_valid = 1'b0;
    end

    // R11: direct load, reserved bits dropped, priority over update
    @(negedge clk);
    cr_wr = 1'b1; cr_wdata = 8'hFF;
    @(negedge clk);
    cr_wr = 1'b0;
    chk(cr_q == 8'hF0, "R11 load", cr_q, 8'hF0);
    @(negedge clk);
    cr_wr = 1'b1; cr_wdata = 8'h5A;
    op_valid = 1'b1; op_code = 4'd0; opa = 8'd1; opb = 8'd1;
    @(negedge clk);
    cr_wr = 1'b0; op_valid = 1'b0;
    chk(cr_q == 8'h50, "R11 priority", cr_q, 8'h50);
    chk(res_valid == 1 && result == 8'd2, "R11 result", result, 2);

    // R12: branch masks against 0xA0
    @(negedge clk);
    cr_wr = 1'b1; cr_wdata = 8'hA0;
    @(negedge clk);
    cr_wr = 1'b0;
    check_branch(8'h80, 1'b1);
    check_branch(8'hA0, 1'b1);
    check_branch(8'h00, 1'b1);
    check_branch(8'hC0, 1'b0);
    check_branch(8'h40, 1'b0);
    check_branch(8'h81, 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule